// File: doc/BRIEF.md
# Seconds Counter RTC with Match Interrupt

This peripheral keeps time as a 32-bit count of seconds. A one-second strobe comes in from outside the block (from the oscillator and prescaler). Each strobe that arrives while counting is switched on moves the count forward. Software sets the time by writing a load value. That value is held back and only replaces the count on the next accepted strobe, so the counter never changes between seconds.

An alarm compares the count with a programmable match value. When a strobe makes the count equal the match value, a raw alarm flag sets. A second, masked view combines that flag with an enable bit and a mask bit, and this masked view drives the interrupt line.

Software acknowledges the alarm by reading a dedicated acknowledge word; writing to that word does nothing. An optional mode makes the counter restart at zero after it reaches the match value, so the block works as a periodic timer. The bus is a single-cycle word-addressed read/write port with combinational read data.

Top module: `sec_rtc`

## Requirements
- R1: After a synchronous active-low reset, the following all read 0 and `irq` is 0: the count (offset 0x00), the match value (0x04), control (0x0C), masked status (0x10) and raw status (0x14).
- R2: A `sec_tick` pulse that arrives while the run bit (control bit 2) is 1 adds one to the count. Pulses that arrive while the run bit is 0 leave the count unchanged.
- R3: A write to the load word (0x08) does not change the count. The written value replaces the count on the first accepted tick after the write, even if counting was off in between. The load word reads back the last value written.
- R4: With the restart bit (control bit 3) at 0, an accepted tick at count 0xFFFFFFFF gives count 0.
- R5: With the restart bit at 1, an accepted tick while the count equals the match value gives count 0.
- R6: Raw status bit 0 (0x14) sets on the accepted tick whose new count equals the match value, whatever the enable and mask bits are.
- R7: Masked status bit 0 (0x10) and `irq` equal raw AND enable (control bit 0) AND NOT mask (control bit 1).
- R8: A read of the acknowledge word (0x18) clears the raw flag from the next cycle on. A write to that word has no effect. If a new match occurs in the same cycle as the read, the flag stays set.
- R9: Control reads back its four bits in bits [3:0] with zeros above. The match word reads back the value written.
- R10: The version word (0x1C) returns the `VERSION` parameter. Writes to 0x00, 0x10, 0x14 and 0x1C are ignored. Reads at offsets at or above 0x20 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| irq | output | 1 | Masked alarm interrupt, active high |

## Verification
On every cycle, the in-line properties check the following:
- the count does not move without an accepted tick;
- a pending load takes priority on a tick;
- the two roll-over paths go to zero;
- a match always sets the raw flag, and an acknowledge read without a match clears it;
- the interrupt stays low while it is disabled or masked.

Other behaviour can only be shown by the bench's scenarios:
- that the load value is held back across a stretch with counting off;
- the bus decode, meaning which offsets ignore writes, what version and unmapped reads return, and that writes to the acknowledge word do nothing;
- the collision where an acknowledge read and a match land in the same cycle.

// File: rtl/sec_rtc_pkg.sv
// Shared definitions for the seconds-counter RTC: word indices of the
// register window and the layout of the control word.
package sec_rtc_pkg;

    // Word index = byte offset / 4.
    localparam logic [2:0] IDX_COUNT = 3'd0;
    localparam logic [2:0] IDX_MATCH = 3'd1;
    localparam logic [2:0] IDX_LOAD  = 3'd2;
    localparam logic [2:0] IDX_CTRL  = 3'd3;
    localparam logic [2:0] IDX_MSTAT = 3'd4;
    localparam logic [2:0] IDX_RSTAT = 3'd5;
    localparam logic [2:0] IDX_ACK   = 3'd6;
    localparam logic [2:0] IDX_VER   = 3'd7;
    localparam int         NUM_WORDS = 8;
    localparam int         CTRL_W    = 4;

    // Control word: bit 3 restart, bit 2 run, bit 1 mask, bit 0 enable.
    typedef struct packed {
        logic restart;
        logic run;
        logic mask;
        logic irq_en;
    } ctrl_t;

endpackage

// File: rtl/sec_rtc_count.sv
// Seconds counter with a deferred load.
// Assumes: tick is a one-cycle strobe. A load written in the same cycle as
// an accepted tick stays pending for the next tick; the tick uses the older
// pending value, if there is one.
module sec_rtc_count #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              restart,
    input  logic [DATA_W-1:0] match,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] load_val,
    output logic              hit
);

    logic              step;
    logic              pend_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] count_nxt;

    assign step = tick & run;

    // Work out the value the counter takes on an accepted tick.
    always_comb begin
        if (pend_q)
            count_nxt = load_q;
        else if (restart && (count_q == match))
            count_nxt = '0;
        else
            count_nxt = count_q + DATA_W'(1);
    end

    // Update the counter and track the pending load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            load_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (step)
                count_q <= count_nxt;
            if (load_wr) begin
                load_q <= load_data;
                pend_q <= 1'b1;
            end else if (step) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign count    = count_q;
    assign load_val = load_q;
    assign hit      = step && (count_nxt == match);

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count_q));
    a_r3_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        step && pend_q |=> count_q == $past(load_q));
    a_r4_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        step && !pend_q && !restart && (count_q == '1) |=> count_q == '0);
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        step && !pend_q && restart && (count_q == match) |=> count_q == '0);

endmodule

// File: rtl/sec_rtc_alarm.sv
// Alarm status: the raw flag sets on a match and clears on an acknowledge
// read; the masked view gates it with enable and mask.
// Assumes: hit and ack_rd are single-cycle. A match wins over an acknowledge
// in the same cycle.
module sec_rtc_alarm (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack_rd,
    input  logic irq_en,
    input  logic mask,
    output logic raw,
    output logic masked
);

    logic raw_q;

    // Keep the raw alarm flag: set on a match, clear on an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= 1'b0;
        else if (hit)
            raw_q <= 1'b1;
        else if (ack_rd)
            raw_q <= 1'b0;
    end

    assign raw    = raw_q;
    assign masked = raw_q & irq_en & ~mask;

    a_r6_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raw_q);
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd && !hit |=> !raw_q);
    a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_rd && !hit |=> $stable(raw_q));

endmodule

// File: rtl/sec_rtc_regs.sv
// Register window: decodes the word-aligned bus, holds control and match,
// forwards load writes and acknowledge reads, and muxes the read data.
// Assumes: one access per bus_sel cycle. Address bits [1:0] are ignored.
module sec_rtc_regs
    import sec_rtc_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter int                ADDR_W  = 6,
    parameter logic [DATA_W-1:0] VERSION = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] count,
    input  logic [DATA_W-1:0] load_val,
    input  logic              raw,
    input  logic              masked,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] match,
    output logic              load_wr,
    output logic              ack_rd
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [2:0]        idx;
    logic              in_map;
    logic              wr_en;
    logic              rd_en;
    logic [1:0]        unused_lsb;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] match_q;

    assign unused_lsb = bus_addr[1:0];
    assign word       = bus_addr[ADDR_W-1:2];
    assign in_map     = (word < WORD_W'(NUM_WORDS));
    assign idx        = word[2:0];
    assign wr_en      = bus_sel & bus_wr & in_map;
    assign rd_en      = bus_sel & ~bus_wr & in_map;
    assign load_wr    = wr_en && (idx == IDX_LOAD);
    assign ack_rd     = rd_en && (idx == IDX_ACK);

    // Hold the writable control and match words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            match_q <= '0;
        end else if (wr_en) begin
            if (idx == IDX_CTRL)
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (idx == IDX_MATCH)
                match_q <= bus_wdata;
        end
    end

    // Select the read data for the addressed word.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (idx)
                IDX_COUNT: bus_rdata = count;
                IDX_MATCH: bus_rdata = match_q;
                IDX_LOAD:  bus_rdata = load_val;
                IDX_CTRL:  bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
                IDX_MSTAT: bus_rdata = {{(DATA_W-1){1'b0}}, masked};
                IDX_RSTAT: bus_rdata = {{(DATA_W-1){1'b0}}, raw};
                IDX_VER:   bus_rdata = VERSION;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign ctrl  = ctrl_q;
    assign match = match_q;

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && !in_map |-> bus_rdata == '0);

endmodule

// File: rtl/sec_rtc.sv
// Seconds-counter RTC top: register window, counter with deferred load and
// match alarm with a gated interrupt.
// Assumes: sec_tick comes from an external one-second prescaler in the clk
// domain; the bus is word aligned.
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter int                ADDR_W  = 6,
    parameter logic [DATA_W-1:0] VERSION = 32'h0001_0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] match;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] load_val;
    logic              load_wr;
    logic              ack_rd;
    logic              hit;
    logic              raw;
    logic              masked;

    sec_rtc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .load_val(load_val), .raw(raw), .masked(masked),
        .ctrl(ctrl), .match(match), .load_wr(load_wr), .ack_rd(ack_rd)
    );

    sec_rtc_count #(.DATA_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick),
        .run(ctrl.run), .restart(ctrl.restart), .match(match),
        .load_wr(load_wr), .load_data(bus_wdata),
        .count(count), .load_val(load_val), .hit(hit)
    );

    sec_rtc_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .ack_rd(ack_rd),
        .irq_en(ctrl.irq_en), .mask(ctrl.mask),
        .raw(raw), .masked(masked)
    );

    assign irq = masked;

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.irq_en || ctrl.mask) |-> !irq);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !irq);

endmodule

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;

    localparam logic [31:0] TB_VER = 32'h0001_0002;
    localparam int N_VEC = 36;
    // Vector: {op[1:0], req[3:0], addr[5:0], data[31:0]}; op 0 write, 1 read-compare, 2 tick.
    localparam logic [43:0] VEC [N_VEC] = '{
        {2'd1, 4'd1,  6'h00, 32'h0},        // R1 count
        {2'd1, 4'd1,  6'h0C, 32'h0},        // R1 control
        {2'd1, 4'd1,  6'h10, 32'h0},        // R1 masked status
        {2'd0, 4'd3,  6'h08, 32'h100},      // R3 load
        {2'd1, 4'd3,  6'h00, 32'h0},        // R3 not yet applied
        {2'd2, 4'd2,  6'h00, 32'h0},        // R2 tick while stopped
        {2'd1, 4'd2,  6'h00, 32'h0},        // R2 ignored
        {2'd0, 4'd9,  6'h0C, 32'h4},        // R9 run
        {2'd1, 4'd9,  6'h0C, 32'h4},        // R9 readback
        {2'd2, 4'd3,  6'h00, 32'h0},
        {2'd1, 4'd3,  6'h00, 32'h100},      // R3 applied on tick
        {2'd2, 4'd2,  6'h00, 32'h0},
        {2'd1, 4'd2,  6'h00, 32'h101},      // R2 increment
        {2'd0, 4'd9,  6'h04, 32'h103},
        {2'd1, 4'd9,  6'h04, 32'h103},      // R9 match readback
        {2'd2, 4'd6,  6'h00, 32'h0},
        {2'd1, 4'd6,  6'h14, 32'h0},        // R6 not yet
        {2'd2, 4'd6,  6'h00, 32'h0},
        {2'd1, 4'd6,  6'h14, 32'h1},        // R6 raw set, enable off
        {2'd1, 4'd7,  6'h10, 32'h0},        // R7 disabled
        {2'd0, 4'd7,  6'h0C, 32'h5},
        {2'd1, 4'd7,  6'h10, 32'h1},        // R7 enabled
        {2'd0, 4'd7,  6'h0C, 32'h7},
        {2'd1, 4'd7,  6'h10, 32'h0},        // R7 masked
        {2'd0, 4'd7,  6'h0C, 32'h5},
        {2'd0, 4'd8,  6'h18, 32'h0},        // R8 write to ack
        {2'd1, 4'd8,  6'h14, 32'h1},        // R8 still set
        {2'd1, 4'd8,  6'h18, 32'h0},        // R8 ack read
        {2'd1, 4'd8,  6'h14, 32'h0},        // R8 cleared
        {2'd1, 4'd10, 6'h1C, TB_VER},       // R10 version
        {2'd0, 4'd10, 6'h1C, 32'hDEAD},
        {2'd1, 4'd10, 6'h1C, TB_VER},       // R10 version read-only
        {2'd0, 4'd10, 6'h00, 32'h55},
        {2'd1, 4'd10, 6'h00, 32'h103},      // R10 count read-only
        {2'd1, 4'd10, 6'h20, 32'h0},        // R10 unmapped
        {2'd1, 4'd9,  6'h08, 32'h100}       // R9/R3 load readback
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sec_rtc #(.DATA_W(32), .ADDR_W(6), .VERSION(TB_VER)) u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < N_VEC; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [5:0]  ad;
            logic [31:0] dt;
            {op, rq, ad, dt} = VEC[i];
            case (op)
                2'd0: wr(ad, dt);
                2'd1: begin
                    rd(ad, v);
                    check($sformatf("R%0d vec%0d", rq, i), v, dt);
                end
                default: tick();
            endcase
        end

        // R4: natural roll-over with restart off (control = enable|run).
        wr(6'h08, 32'hFFFF_FFFF);
        tick();
        rd(6'h00, v); check("R4 loaded max", v, 32'hFFFF_FFFF);
        tick();
        rd(6'h00, v); check("R4 rolled to zero", v, 32'h0);
        check("R7 irq low after ack", {31'b0, irq}, 32'h0);

        // R5: restart at match.
        wr(6'h04, 32'd5);
        wr(6'h08, 32'd3);
        wr(6'h0C, 32'hD);
        tick(); tick(); tick();
        rd(6'h00, v); check("R5 reached match", v, 32'd5);
        check("R7 irq on match", {31'b0, irq}, 32'h1);
        tick();
        rd(6'h00, v); check("R5 restart to zero", v, 32'h0);

        // R8: acknowledge and match in the same cycle, match wins.
        rd(6'h18, v);
        check("R8 irq cleared", {31'b0, irq}, 32'h0);
        tick(); tick(); tick(); tick();
        @(negedge clk);
        sec_tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h18;
        @(negedge clk);
        sec_tick = 1'b0; bus_sel = 1'b0;
        rd(6'h14, v); check("R8 set wins over ack", v, 32'h1);
        rd(6'h00, v); check("R8 count at match", v, 32'd5);

        // R3: load held across a stopped stretch.
        wr(6'h0C, 32'h0);
        wr(6'h08, 32'h77);
        tick(); tick();
        rd(6'h00, v); check("R2 stopped count", v, 32'd5);
        wr(6'h0C, 32'h4);
        rd(6'h00, v); check("R3 not applied on enable", v, 32'd5);
        tick();
        rd(6'h00, v); check("R3 held load applied", v, 32'h77);

        // R1: reset in mid-run.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(6'h00, v); check("R1 count after reset", v, 32'h0);
        rd(6'h04, v); check("R1 match after reset", v, 32'h0);
        rd(6'h14, v); check("R1 raw after reset", v, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        finish_run();
    end

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule